// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the address phase of an I2C transfer selects the local target. It holds two own addresses. The primary address is 10 bits wide and can be matched either as a 7-bit address or as a full 10-bit address. The secondary address is 7 bits wide, and a 3-bit mask code turns its lowest bits into don't-care bits. General-call acceptance has its own enable.

The bit-level front end presents each received address byte with a one-cycle valid strobe, and flags every START or repeated START. The block returns an ACK decision, a sticky match flag, the transfer direction and a 7-bit match code. A write-1 clear input drops the match flag together with any pending master start request. Deasserting the block enable resets all match state. The own-address configuration is kept.

Top module: `i2c_addr_match`

## Requirements
- R1: With the primary enabled in 7-bit mode (mode bit 0), a first byte whose bits 7:1 equal primary bits 7:1 is acknowledged. The match flag is set, the code takes byte bits 7:1 and the direction takes byte bit 0 (0 = target receives, 1 = target transmits).
- R2: The secondary compares against byte bits 7:1 with its lowest N bits ignored, where N is the mask code (0..7). Code 7 accepts every non-reserved 7-bit address.
- R3: When the mask code is nonzero, the secondary never accepts a 7-bit address of the form 0000xxx or 1111xxx.
- R4: In 10-bit mode (mode bit 1), a first byte equal to 11110, primary bits 9:8, 0 is acknowledged without setting the flag. A following byte equal to primary bits 7:0 completes the match: code = {11110, bits 9:8}, direction 0. A different second byte is not acknowledged and sets no flag.
- R5: After a completed 10-bit write match, a repeated START with the same header and R/W=1 matches at once with direction 1. Without that earlier match, the same byte is not acknowledged.
- R6: Byte 0x00 (general call) is acknowledged with code 0 and direction 0 only while the general-call enable is 1.
- R7: An address whose enable is 0 never matches.
- R8: A write to an address value or its mode or mask while that address is enabled is ignored.
- R9: The ACK output changes one clock after an address strobe and is cleared one clock after a START. Bytes arriving after the decision of a transfer change nothing until the next START.
- R10: The match flag stays set until the clear input is pulsed. That clear also drops the pending master start request.
- R11: While the block enable is 0, the ACK, match flag, direction, code and pending start request are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| blk_en | input | 1 | Block enable; 0 resets match state |
| pri_wr | input | 1 | Write strobe for primary address and mode |
| pri_addr_wdata | input | 10 | Primary own-address write value |
| pri_ten_wdata | input | 1 | Primary mode write value (1 = 10-bit) |
| pri_en | input | 1 | Primary address enable |
| sec_wr | input | 1 | Write strobe for secondary address and mask |
| sec_addr_wdata | input | 7 | Secondary own-address write value |
| sec_mask_wdata | input | 3 | Secondary mask code write value |
| sec_en | input | 1 | Secondary address enable |
| gcall_en | input | 1 | General-call acceptance enable |
| bus_start | input | 1 | START or repeated START seen |
| addr_vld | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Received address byte |
| match_clr | input | 1 | Write-1 clear of match flag and start request |
| mreq_set | input | 1 | Sets the pending master start request |
| ack_o | output | 1 | ACK decision for the latest address byte |
| match_o | output | 1 | Sticky match flag |
| dir_o | output | 1 | Captured direction |
| code_o | output | 7 | Captured match code |
| mreq_pend_o | output | 1 | Pending master start request |

## Verification
Random first bytes are tried against random primary addresses, secondary addresses, mask codes and enable sets. Some bytes are drawn near the secondary address, so that masked and unmasked bits are both exercised. Reserved bytes are drawn on purpose, which separates a correct masked compare from one that forgets the reserved check. Directed 10-bit sequences separate a correct second-byte compare, and a read restart with history, from the same read restart without history. General-call bytes with the enable off, writes to enabled addresses, stray bytes after a decision, and the clear and disable inputs show that each one affects only what it should.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
   typedef enum logic [1:0] {
      AM_IDLE   = 2'd0,
      AM_FIRST  = 2'd1,
      AM_SECOND = 2'd2,
      AM_DONE   = 2'd3
   } am_state_e;

   localparam logic [4:0] AM_HDR10 = 5'b11110;
   localparam int         AM_HDR_W = 5;
endpackage

// File: rtl/i2c_am_cfg.sv
module i2c_am_cfg #(
   parameter int PRI_W  = 10,
   parameter int SEC_W  = 7,
   parameter int MASK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pri_wr,
   input  logic [PRI_W-1:0]  pri_addr_wdata,
   input  logic              pri_ten_wdata,
   input  logic              pri_en,
   input  logic              sec_wr,
   input  logic [SEC_W-1:0]  sec_addr_wdata,
   input  logic [MASK_W-1:0] sec_mask_wdata,
   input  logic              sec_en,
   output logic [PRI_W-1:0]  pri_addr_q,
   output logic              pri_ten_q,
   output logic [SEC_W-1:0]  sec_addr_q,
   output logic [MASK_W-1:0] sec_mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_addr_q <= '0;
         pri_ten_q  <= 1'b0;
      end else if (pri_wr && !pri_en) begin
         pri_addr_q <= pri_addr_wdata;
         pri_ten_q  <= pri_ten_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_addr_q <= '0;
         sec_mask_q <= '0;
      end else if (sec_wr && !sec_en) begin
         sec_addr_q <= sec_addr_wdata;
         sec_mask_q <= sec_mask_wdata;
      end
   end

   // R8: enabled addresses keep their configuration
   p_pri_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pri_en |=> $stable(pri_addr_q) && $stable(pri_ten_q));
   p_sec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sec_en |=> $stable(sec_addr_q) && $stable(sec_mask_q));
endmodule

// File: rtl/i2c_am_decode.sv
module i2c_am_decode
   import i2c_am_pkg::*;
#(
   parameter int PRI_W     = 10,
   parameter int SEC_W     = 7,
   parameter int MASK_W    = 3,
   parameter bit RSV_CHECK = 1'b1
) (
   input  logic [PRI_W-1:0]  pri_addr_q,
   input  logic              pri_ten_q,
   input  logic              pri_en,
   input  logic [SEC_W-1:0]  sec_addr_q,
   input  logic [MASK_W-1:0] sec_mask_q,
   input  logic              sec_en,
   input  logic              gcall_en,
   input  logic [7:0]        byte_in,
   output logic              hit7,
   output logic              hdr_hit,
   output logic              lo_hit
);
   localparam int HI_W = PRI_W - 8;

   logic [SEC_W-1:0] a7;
   logic [SEC_W-1:0] keep;
   logic             pri7_hit, sec_hit, gc_hit, rsv;

   assign a7 = byte_in[7:1];

   for (genvar i = 0; i < SEC_W; i++) begin : g_keep
      assign keep[i] = (int'(sec_mask_q) <= i);
   end

   if (RSV_CHECK) begin : g_rsv
      assign rsv = (sec_mask_q != '0) &&
                   ((a7[SEC_W-1 -: 4] == 4'b0000) || (a7[SEC_W-1 -: 4] == 4'b1111));
   end else begin : g_norsv
      assign rsv = 1'b0;
   end

   assign pri7_hit = pri_en && !pri_ten_q && (a7 == pri_addr_q[7:1]);
   assign sec_hit  = sec_en && ((a7 & keep) == (sec_addr_q & keep)) && !rsv;
   assign gc_hit   = gcall_en && (byte_in == 8'h00);
   assign hit7     = pri7_hit || sec_hit || gc_hit;

   assign hdr_hit  = pri_en && pri_ten_q &&
                     (byte_in[7:3] == AM_HDR10) &&
                     (byte_in[2:1] == pri_addr_q[PRI_W-1 -: HI_W]);
   assign lo_hit   = (byte_in == pri_addr_q[7:0]);

   // R3: secondary never accepts a reserved address with a nonzero mask
   always_comb begin
      if (RSV_CHECK && sec_hit && (sec_mask_q != '0))
         p_rsv_reject_r3: assert (a7[SEC_W-1 -: 4] != 4'b0000 && a7[SEC_W-1 -: 4] != 4'b1111);
   end
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
   import i2c_am_pkg::*;
#(
   parameter int PRI_W = 10,
   parameter int SEC_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_en,
   input  logic              bus_start,
   input  logic              addr_vld,
   input  logic [7:0]        addr_byte,
   input  logic              match_clr,
   input  logic              mreq_set,
   input  logic              hit7,
   input  logic              hdr_hit,
   input  logic              lo_hit,
   input  logic [1:0]        pri_hi,
   output logic              ack_o,
   output logic              match_o,
   output logic              dir_o,
   output logic [SEC_W-1:0]  code_o,
   output logic              mreq_pend_o
);
   am_state_e        st_q, st_d;
   logic             ack_d, ten_ok_q, ten_ok_d;
   logic             take, take_dir;
   logic [SEC_W-1:0] take_code, hdr_code;

   assign hdr_code = {AM_HDR10, pri_hi};

   always_comb begin
      st_d      = st_q;
      ack_d     = ack_o;
      ten_ok_d  = ten_ok_q;
      take      = 1'b0;
      take_dir  = 1'b0;
      take_code = '0;
      if (bus_start) begin
         st_d  = AM_FIRST;
         ack_d = 1'b0;
      end else if (addr_vld) begin
         case (st_q)
            AM_FIRST: begin
               st_d = AM_DONE;
               if (hdr_hit && !addr_byte[0]) begin
                  st_d  = AM_SECOND;
                  ack_d = 1'b1;
               end else if (hdr_hit && ten_ok_q) begin
                  ack_d     = 1'b1;
                  take      = 1'b1;
                  take_dir  = 1'b1;
                  take_code = hdr_code;
               end else if (!hdr_hit && hit7) begin
                  ack_d     = 1'b1;
                  ten_ok_d  = 1'b0;
                  take      = 1'b1;
                  take_dir  = addr_byte[0];
                  take_code = addr_byte[7:1];
               end else begin
                  ack_d    = 1'b0;
                  ten_ok_d = 1'b0;
               end
            end
            AM_SECOND: begin
               st_d = AM_DONE;
               if (lo_hit) begin
                  ack_d     = 1'b1;
                  ten_ok_d  = 1'b1;
                  take      = 1'b1;
                  take_code = hdr_code;
               end else begin
                  ack_d    = 1'b0;
                  ten_ok_d = 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= AM_IDLE;
         ack_o       <= 1'b0;
         ten_ok_q    <= 1'b0;
         match_o     <= 1'b0;
         dir_o       <= 1'b0;
         code_o      <= '0;
         mreq_pend_o <= 1'b0;
      end else if (!blk_en) begin
         st_q        <= AM_IDLE;
         ack_o       <= 1'b0;
         ten_ok_q    <= 1'b0;
         match_o     <= 1'b0;
         dir_o       <= 1'b0;
         code_o      <= '0;
         mreq_pend_o <= 1'b0;
      end else begin
         st_q     <= st_d;
         ack_o    <= ack_d;
         ten_ok_q <= ten_ok_d;
         if (take) begin
            match_o <= 1'b1;
            dir_o   <= take_dir;
            code_o  <= take_code;
         end else if (match_clr) begin
            match_o <= 1'b0;
         end
         if (mreq_set)       mreq_pend_o <= 1'b1;
         else if (match_clr) mreq_pend_o <= 1'b0;
      end
   end

   // R9: ack tracks strobes and starts only
   p_ack_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> !ack_o);
   p_ack_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      blk_en && !bus_start && !addr_vld |=> $stable(ack_o));
   // R10: sticky flag and clear
   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      blk_en && match_o && !match_clr |=> match_o);
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      match_clr && !addr_vld && !mreq_set |=> !match_o && !mreq_pend_o);
   // R1: the flag only rises on an address strobe
   p_flag_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_o) |-> $past(addr_vld));
   // R11: disabled block holds no match state
   p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_en |=> !ack_o && !match_o && !mreq_pend_o && code_o == '0);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
   parameter int PRI_W     = 10,
   parameter int SEC_W     = 7,
   parameter int MASK_W    = 3,
   parameter bit RSV_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_en,
   input  logic              pri_wr,
   input  logic [PRI_W-1:0]  pri_addr_wdata,
   input  logic              pri_ten_wdata,
   input  logic              pri_en,
   input  logic              sec_wr,
   input  logic [SEC_W-1:0]  sec_addr_wdata,
   input  logic [MASK_W-1:0] sec_mask_wdata,
   input  logic              sec_en,
   input  logic              gcall_en,
   input  logic              bus_start,
   input  logic              addr_vld,
   input  logic [7:0]        addr_byte,
   input  logic              match_clr,
   input  logic              mreq_set,
   output logic              ack_o,
   output logic              match_o,
   output logic              dir_o,
   output logic [SEC_W-1:0]  code_o,
   output logic              mreq_pend_o
);
   localparam int HI_W = PRI_W - 8;

   if (PRI_W != 10) begin : g_chk_pri
      $error("i2c_addr_match: PRI_W must be 10");
   end
   if (SEC_W != 7) begin : g_chk_sec
      $error("i2c_addr_match: SEC_W must be 7");
   end
   if ((1 << MASK_W) > SEC_W + 1) begin : g_chk_mask
      $error("i2c_addr_match: MASK_W too wide for SEC_W");
   end

   logic [PRI_W-1:0]  pri_addr_q;
   logic              pri_ten_q;
   logic [SEC_W-1:0]  sec_addr_q;
   logic [MASK_W-1:0] sec_mask_q;
   logic              hit7, hdr_hit, lo_hit;

   i2c_am_cfg #(.PRI_W(PRI_W), .SEC_W(SEC_W), .MASK_W(MASK_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .pri_wr(pri_wr), .pri_addr_wdata(pri_addr_wdata), .pri_ten_wdata(pri_ten_wdata),
      .pri_en(pri_en),
      .sec_wr(sec_wr), .sec_addr_wdata(sec_addr_wdata), .sec_mask_wdata(sec_mask_wdata),
      .sec_en(sec_en),
      .pri_addr_q(pri_addr_q), .pri_ten_q(pri_ten_q),
      .sec_addr_q(sec_addr_q), .sec_mask_q(sec_mask_q)
   );

   i2c_am_decode #(.PRI_W(PRI_W), .SEC_W(SEC_W), .MASK_W(MASK_W),
                   .RSV_CHECK(RSV_CHECK)) u_dec (
      .pri_addr_q(pri_addr_q), .pri_ten_q(pri_ten_q), .pri_en(pri_en),
      .sec_addr_q(sec_addr_q), .sec_mask_q(sec_mask_q), .sec_en(sec_en),
      .gcall_en(gcall_en), .byte_in(addr_byte),
      .hit7(hit7), .hdr_hit(hdr_hit), .lo_hit(lo_hit)
   );

   i2c_am_seq #(.PRI_W(PRI_W), .SEC_W(SEC_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .blk_en(blk_en),
      .bus_start(bus_start), .addr_vld(addr_vld), .addr_byte(addr_byte),
      .match_clr(match_clr), .mreq_set(mreq_set),
      .hit7(hit7), .hdr_hit(hdr_hit), .lo_hit(lo_hit),
      .pri_hi(pri_addr_q[PRI_W-1 -: HI_W]),
      .ack_o(ack_o), .match_o(match_o), .dir_o(dir_o), .code_o(code_o),
      .mreq_pend_o(mreq_pend_o)
   );
endmodule

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       blk_en = 1'b0;
   logic       pri_wr = 1'b0;
   logic [9:0] pri_addr_wdata = '0;
   logic       pri_ten_wdata = 1'b0;
   logic       pri_en = 1'b0;
   logic       sec_wr = 1'b0;
   logic [6:0] sec_addr_wdata = '0;
   logic [2:0] sec_mask_wdata = '0;
   logic       sec_en = 1'b0;
   logic       gcall_en = 1'b0;
   logic       bus_start = 1'b0;
   logic       addr_vld = 1'b0;
   logic [7:0] addr_byte = '0;
   logic       match_clr = 1'b0;
   logic       mreq_set = 1'b0;
   logic       ack_o, match_o, dir_o, mreq_pend_o;
   logic [6:0] code_o;

   int total = 0;
   int bad = 0;

   // model of programmed configuration
   logic [9:0] m_pa;
   logic       m_pten;
   logic [6:0] m_sa;
   logic [2:0] m_mask;

   always #2.5 clk = ~clk;

   i2c_addr_match dut_i (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_pri(input logic [9:0] a, input logic ten);
      @(negedge clk); pri_wr = 1'b1; pri_addr_wdata = a; pri_ten_wdata = ten;
      @(negedge clk); pri_wr = 1'b0;
   endtask

   task automatic cfg_sec(input logic [6:0] a, input logic [2:0] m);
      @(negedge clk); sec_wr = 1'b1; sec_addr_wdata = a; sec_mask_wdata = m;
      @(negedge clk); sec_wr = 1'b0;
   endtask

   task automatic do_start();
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); addr_vld = 1'b1; addr_byte = b;
      @(negedge clk); addr_vld = 1'b0;
   endtask

   task automatic clear();
      @(negedge clk); match_clr = 1'b1;
      @(negedge clk); match_clr = 1'b0;
   endtask

   function automatic logic exp_hit7(input logic [7:0] b);
      logic [6:0] a7, keep;
      logic       rsv;
      a7   = b[7:1];
      keep = 7'h7f << m_mask;
      rsv  = (m_mask != 0) && (a7[6:3] == 4'h0 || a7[6:3] == 4'hf);
      return (pri_en && !m_pten && a7 == m_pa[7:1]) ||
             (sec_en && ((a7 & keep) == (m_sa & keep)) && !rsv) ||
             (gcall_en && b == 8'h00);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state, R11
      chk("R11 reset ack", ack_o, 0);
      chk("R11 reset flag", match_o, 0);
      chk("R11 reset req", mreq_pend_o, 0);
      blk_en = 1'b1;

      // R1 directed 7-bit primary
      m_pa = 10'h0a6; m_pten = 0; cfg_pri(m_pa, 0); pri_en = 1;
      do_start(); send(8'ha7);
      chk("R1 ack", ack_o, 1); chk("R1 flag", match_o, 1);
      chk("R1 code", code_o, 7'h53); chk("R1 dir", dir_o, 1);
      // R9 stray byte after decision ignored
      send(8'h00);
      chk("R9 stray ack", ack_o, 1); chk("R9 stray code", code_o, 7'h53);
      do_start();
      chk("R9 start clears ack", ack_o, 0);
      chk("R10 flag sticky", match_o, 1);
      // R10 clear drops flag and request
      @(negedge clk); mreq_set = 1; @(negedge clk); mreq_set = 0;
      chk("R10 req set", mreq_pend_o, 1);
      clear();
      chk("R10 clear flag", match_o, 0); chk("R10 clear req", mreq_pend_o, 0);

      // R8 write while enabled is ignored
      cfg_pri(10'h020, 0);
      do_start(); send(8'ha6);
      chk("R8 old address still matches", ack_o, 1);
      clear();
      do_start(); send(8'h20);
      chk("R8 new address ignored", ack_o, 0);

      // R7 disabled primary
      pri_en = 0;
      do_start(); send(8'ha6);
      chk("R7 disabled primary", ack_o, 0);

      // R6 general call
      do_start(); send(8'h00);
      chk("R6 gc off", ack_o, 0); chk("R6 gc off flag", match_o, 0);
      gcall_en = 1;
      do_start(); send(8'h00);
      chk("R6 gc on", ack_o, 1); chk("R6 gc code", code_o, 0); chk("R6 gc dir", dir_o, 0);
      clear(); gcall_en = 0;

      // R3 reserved rejection with mask 1, and accepted with mask 0
      m_sa = 7'h05; m_mask = 3'd1; cfg_sec(m_sa, m_mask); sec_en = 1;
      do_start(); send({7'h04, 1'b0});
      chk("R3 reserved masked rejected", ack_o, 0);
      sec_en = 0; m_mask = 3'd0; cfg_sec(m_sa, m_mask); sec_en = 1;
      do_start(); send({7'h05, 1'b0});
      chk("R3 reserved unmasked accepted", ack_o, 1);
      clear();
      // R2 mask 7 accepts any non-reserved
      sec_en = 0; m_mask = 3'd7; cfg_sec(m_sa, m_mask); sec_en = 1;
      do_start(); send({7'h6a, 1'b1});
      chk("R2 mask7 accept", ack_o, 1); chk("R2 mask7 code", code_o, 7'h6a);
      clear();
      do_start(); send({7'h7c, 1'b1});
      chk("R3 mask7 reserved", ack_o, 0);
      sec_en = 0;

      // R4 10-bit write match
      m_pa = 10'h2c5; m_pten = 1; cfg_pri(m_pa, 1); pri_en = 1;
      do_start(); send(8'hf4);
      chk("R4 header ack", ack_o, 1); chk("R4 header no flag", match_o, 0);
      send(8'hc5);
      chk("R4 second ack", ack_o, 1); chk("R4 flag", match_o, 1);
      chk("R4 code", code_o, 7'h7a); chk("R4 dir", dir_o, 0);
      clear();
      // R5 repeated start read
      do_start(); send(8'hf5);
      chk("R5 read restart ack", ack_o, 1); chk("R5 flag", match_o, 1);
      chk("R5 dir", dir_o, 1); chk("R5 code", code_o, 7'h7a);
      clear();
      // R4 wrong second byte, then R5 without history
      do_start(); send(8'hf4); send(8'hc4);
      chk("R4 wrong second nack", ack_o, 0); chk("R4 wrong second flag", match_o, 0);
      do_start(); send(8'hf5);
      chk("R5 no history nack", ack_o, 0);
      pri_en = 0;

      // R11 disable clears state
      m_pa = 10'h0a6; m_pten = 0; cfg_pri(m_pa, 0); pri_en = 1;
      do_start(); send(8'ha6);
      @(negedge clk); mreq_set = 1; @(negedge clk); mreq_set = 0;
      blk_en = 0; @(negedge clk);
      chk("R11 disable flag", match_o, 0); chk("R11 disable ack", ack_o, 0);
      chk("R11 disable req", mreq_pend_o, 0); chk("R11 disable code", code_o, 0);
      blk_en = 1;

      // random 7-bit traffic, R1 R2 R3 R6 R7
      for (int it = 0; it < 300; it++) begin
         logic [7:0] b;
         logic       e;
         if (it % 16 == 0) begin
            pri_en = 0; sec_en = 0;
            m_pa = 10'($urandom); m_pten = 0; cfg_pri(m_pa, 0);
            m_sa = 7'($urandom); m_mask = 3'($urandom); cfg_sec(m_sa, m_mask);
            pri_en = 1'($urandom); sec_en = 1'($urandom); gcall_en = 1'($urandom);
         end
         case ($urandom % 4)
            0: b = 8'($urandom);
            1: b = {m_sa ^ 7'($urandom % 8), 1'($urandom)};
            2: b = {m_pa[7:1], 1'($urandom)};
            default: b = {(($urandom % 2) ? 4'h0 : 4'hf), 3'($urandom), 1'($urandom)};
         endcase
         e = exp_hit7(b);
         do_start(); send(b);
         chk("R2 random ack", ack_o, e);
         chk("R1 random flag", match_o, e);
         if (e) begin
            chk("R1 random code", code_o, b[7:1]);
            chk("R1 random dir", dir_o, b[0]);
         end
         clear();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule